// File: doc/BRIEF.md
# Framed serial register-command receiver

This block accepts register commands from a host over one serial data lane. The lane has its own bit clock and its own frame-sync input, separate from the clock of the core that owns the registers. Every command is a fixed 32-bit word shifted in most significant bit first. A single sync pulse marks where each word starts. The block deserializes the word and discards empty words. It sorts the remaining words into register writes and read requests, and rejects malformed ones.

Accepted commands cross into the core clock domain through a toggle handshake with two-flop synchronizers in each direction. In the core domain the block raises a one-cycle write strobe or read strobe, with the register address and write data beside it. A malformed command raises a one-cycle error pulse instead. The register file and the path that returns read data are outside this block.

Top module: `cmd_frame_rx`

## Requirements
- R1: The sync input is sampled high on the serial clock edge one bit before the most significant bit. The next 32 serial edges then capture bits 31 down to 0. The field layout is: bit 31 occupied flag, bit 30 write flag, bits 29:26 rank, bits 25:16 address, bits 15:0 data.
- R2: A word whose occupied flag (bit 31) is 0 produces no write strobe, no read strobe and no error pulse.
- R3: An occupied word with the write flag set and a zero rank produces one regWrStb pulse. regAddr equals bits 25:16 and regWrData equals bits 15:0.
- R4: An occupied word with the write flag clear, a zero rank and a zero data field produces one regRdStb pulse with regAddr equal to bits 25:16. While regRdStb is high, regWrData is zero.
- R5: A read request (write flag clear) whose data field is nonzero produces one frameErr pulse and no read or write strobe.
- R6: An occupied word with a nonzero rank field produces one frameErr pulse and no read or write strobe, whether the write flag is set or clear.
- R7: A sync pulse sampled before all 32 bits of a word are in discards the partial word. Decoding restarts from the bit that follows the new sync.
- R8: A sync pulse sampled on the same edge as bit 0 of a word is accepted. Both that word and the following word are decoded (back-to-back operation).
- R9: At most one of regWrStb, regRdStb and frameErr is high at any time, and each pulse lasts exactly one core clock cycle.
- R10: While either reset is asserted, and after reset until the first command arrives, all strobes are low.
- R11: Each accepted word is delivered to the core domain exactly once, in the order the words arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serClk | input | 1 | Serial lane bit clock |
| serRstN | input | 1 | Asynchronous active-low reset, serial domain |
| serSync | input | 1 | Frame-sync input, high one bit before the MSB |
| serData | input | 1 | Serial data lane, MSB first |
| coreClk | input | 1 | Core clock |
| coreRstN | input | 1 | Asynchronous active-low reset, core domain |
| regWrStb | output | 1 | One-cycle register write strobe |
| regRdStb | output | 1 | One-cycle register read-request strobe |
| frameErr | output | 1 | One-cycle malformed-command pulse |
| regAddr | output | 10 | Register address of the last delivered command |
| regWrData | output | 16 | Write data of the last delivered command |

## Verification
The assertions assume that each command handshake completes before the next word finishes. In practice this means the core clock is fast enough for two synchronizer passes in each direction within 32 serial bit periods. They also assume that sync pulses are single bit periods. The bench drives the lane on falling serial edges, with sync held for exactly one bit. It runs the core clock at two and a half times the serial rate, so even back-to-back words leave the handshake idle long before the next word completes.

// File: rtl/cfrx_pkg.sv
package cfrx_pkg;
  localparam int FRAME_W  = 32;
  localparam int RANK_W   = 4;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 16;
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int VALID_POS = FRAME_W - 1;
  localparam int WRITE_POS = FRAME_W - 2;
  localparam int ADDR_LSB  = DATA_W;
  localparam int RANK_LSB  = DATA_W + ADDR_W;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2,
    ACC_ERR  = 2'd3
  } accKind_t;

  typedef struct packed {
    logic shiftEn;
    logic frameDone;
  } ctlStrb_t;

  typedef struct packed {
    accKind_t            kind;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
  } accRec_t;
endpackage

// File: rtl/cfrx_ctl.sv
module cfrx_ctl
  import cfrx_pkg::*;
(
  input  logic     serClk,
  input  logic     serRstN,
  input  logic     serSync,
  output ctlStrb_t strb
);
  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  assign lastBit = busy && (bitCnt == CNT_W'(FRAME_W - 1));

  always_comb begin
    strb.shiftEn   = busy;
    strb.frameDone = lastBit;
  end

  // A sync always restarts alignment, which aborts any partial word.
  always_ff @(posedge serClk or negedge serRstN) begin
    if (!serRstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (serSync) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (lastBit) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (busy) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfrx_dp.sv
module cfrx_dp
  import cfrx_pkg::*;
(
  input  logic     serClk,
  input  logic     serRstN,
  input  logic     serData,
  input  ctlStrb_t strb,
  input  logic     xferBusy,
  output accRec_t  rec,
  output logic     launch
);
  logic [FRAME_W-2:0] shReg;
  logic [FRAME_W-1:0] word;
  logic               isValid;
  logic               isWrite;
  logic [RANK_W-1:0]  rankF;
  logic [ADDR_W-1:0]  addrF;
  logic [DATA_W-1:0]  dataF;
  accKind_t           kindNext;

  assign word    = {shReg, serData};
  assign isValid = word[VALID_POS];
  assign isWrite = word[WRITE_POS];
  assign rankF   = word[RANK_LSB +: RANK_W];
  assign addrF   = word[ADDR_LSB +: ADDR_W];
  assign dataF   = word[0 +: DATA_W];

  always_comb begin
    if (!isValid)
      kindNext = ACC_NONE;
    else if (rankF != '0)
      kindNext = ACC_ERR;
    else if (isWrite)
      kindNext = ACC_WR;
    else if (dataF != '0)
      kindNext = ACC_ERR;
    else
      kindNext = ACC_RD;
  end

  always_ff @(posedge serClk or negedge serRstN) begin
    if (!serRstN)
      shReg <= '0;
    else if (strb.shiftEn)
      shReg <= word[FRAME_W-2:0];
  end

  always_ff @(posedge serClk or negedge serRstN) begin
    if (!serRstN) begin
      rec    <= '{kind: ACC_NONE, addr: '0, data: '0};
      launch <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (strb.frameDone && kindNext != ACC_NONE && !xferBusy) begin
        rec    <= '{kind: kindNext, addr: addrF, data: dataF};
        launch <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfrx_cdc.sv
module cfrx_cdc
  import cfrx_pkg::*;
(
  input  logic              serClk,
  input  logic              serRstN,
  input  logic              launch,
  input  accRec_t           rec,
  output logic              xferBusy,
  input  logic              coreClk,
  input  logic              coreRstN,
  output logic              regWrStb,
  output logic              regRdStb,
  output logic              frameErr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData
);
  logic reqTgl, ackS1, ackS2;
  logic reqS1, reqS2, reqS3;
  logic seen;

  // Serial side: flip the request, wait for the acknowledge to come back.
  always_ff @(posedge serClk or negedge serRstN) begin
    if (!serRstN) begin
      reqTgl <= 1'b0;
      ackS1  <= 1'b0;
      ackS2  <= 1'b0;
    end else begin
      ackS1 <= reqS3;
      ackS2 <= ackS1;
      if (launch)
        reqTgl <= ~reqTgl;
    end
  end

  assign xferBusy = reqTgl ^ ackS2;

  // Core side: synchronize request, detect a change, capture held record.
  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      reqS1 <= 1'b0;
      reqS2 <= 1'b0;
      reqS3 <= 1'b0;
    end else begin
      reqS1 <= reqTgl;
      reqS2 <= reqS1;
      reqS3 <= reqS2;
    end
  end

  assign seen = reqS2 ^ reqS3;

  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      regWrStb  <= 1'b0;
      regRdStb  <= 1'b0;
      frameErr  <= 1'b0;
      regAddr   <= '0;
      regWrData <= '0;
    end else begin
      regWrStb <= seen && (rec.kind == ACC_WR);
      regRdStb <= seen && (rec.kind == ACC_RD);
      frameErr <= seen && (rec.kind == ACC_ERR);
      if (seen) begin
        regAddr   <= rec.addr;
        regWrData <= rec.data;
      end
    end
  end
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cfrx_pkg::*;
(
  input  logic              serClk,
  input  logic              serRstN,
  input  logic              serSync,
  input  logic              serData,
  input  logic              coreClk,
  input  logic              coreRstN,
  output logic              regWrStb,
  output logic              regRdStb,
  output logic              frameErr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData
);
  ctlStrb_t ctlStrb;
  accRec_t  accRec;
  logic     launch;
  logic     xferBusy;

  cfrx_ctl u_ctl (
    .serClk  (serClk),
    .serRstN (serRstN),
    .serSync (serSync),
    .strb    (ctlStrb)
  );

  cfrx_dp u_dp (
    .serClk   (serClk),
    .serRstN  (serRstN),
    .serData  (serData),
    .strb     (ctlStrb),
    .xferBusy (xferBusy),
    .rec      (accRec),
    .launch   (launch)
  );

  cfrx_cdc u_cdc (
    .serClk    (serClk),
    .serRstN   (serRstN),
    .launch    (launch),
    .rec       (accRec),
    .xferBusy  (xferBusy),
    .coreClk   (coreClk),
    .coreRstN  (coreRstN),
    .regWrStb  (regWrStb),
    .regRdStb  (regRdStb),
    .frameErr  (frameErr),
    .regAddr   (regAddr),
    .regWrData (regWrData)
  );
endmodule

// File: rtl/cfrx_checker.sv
module cfrx_checker
  import cfrx_pkg::*;
(
  input logic              serClk,
  input logic              serRstN,
  input logic              coreClk,
  input logic              coreRstN,
  input logic              frameDone,
  input logic              launch,
  input logic              xferBusy,
  input logic              regWrStb,
  input logic              regRdStb,
  input logic              frameErr,
  input logic [DATA_W-1:0] regWrData
);
  // R9: never two kinds of pulse at once
  a_r9_exclusive: assert property (@(posedge coreClk) disable iff (!coreRstN)
    $onehot0({regWrStb, regRdStb, frameErr}));

  // R9: each pulse is a single core cycle
  a_r9_wr_single: assert property (@(posedge coreClk) disable iff (!coreRstN)
    regWrStb |=> !regWrStb);
  a_r9_rd_single: assert property (@(posedge coreClk) disable iff (!coreRstN)
    regRdStb |=> !regRdStb);
  a_r9_err_single: assert property (@(posedge coreClk) disable iff (!coreRstN)
    frameErr |=> !frameErr);

  // R4: a read request carries zero data
  a_r4_rd_zero_data: assert property (@(posedge coreClk) disable iff (!coreRstN)
    regRdStb |-> (regWrData == '0));

  // R1: completed words are at least one bit period apart
  a_r1_done_spacing: assert property (@(posedge serClk) disable iff (!serRstN)
    frameDone |=> !frameDone);

  // R11: a launched command occupies the handshake until acknowledged
  a_r11_launch_holds: assert property (@(posedge serClk) disable iff (!serRstN)
    launch |=> xferBusy);
endmodule

bind cmd_frame_rx cfrx_checker u_chk (
  .serClk    (serClk),
  .serRstN   (serRstN),
  .coreClk   (coreClk),
  .coreRstN  (coreRstN),
  .frameDone (ctlStrb.frameDone),
  .launch    (launch),
  .xferBusy  (xferBusy),
  .regWrStb  (regWrStb),
  .regRdStb  (regRdStb),
  .frameErr  (frameErr),
  .regWrData (regWrData)
);

// File: tb/cmd_frame_rx_test.sv
module cmd_frame_rx_test;
  localparam int CORE_PERIOD = 4;
  localparam int SER_PERIOD  = 10;
  localparam int NVEC        = 9;
  localparam int WAITC       = 40;

  // {word[31:0], kind[1:0]}: kind 0 none, 1 write, 2 read, 3 error
  localparam logic [33:0] VEC [NVEC] = '{
    {32'hC155A5C3, 2'd1},
    {32'h83FF0000, 2'd2},
    {32'h7FFFFFFF, 2'd0},
    {32'h80120001, 2'd3},
    {32'hC4200BEE, 2'd3},
    {32'hA0010000, 2'd3},
    {32'hC000FFFF, 2'd1},
    {32'hC2000000, 2'd1},
    {32'h00000000, 2'd0}
  };

  logic serClk = 0, coreClk = 0;
  logic serRstN = 0, coreRstN = 0;
  logic serSync = 0, serData = 0;
  logic regWrStb, regRdStb, frameErr;
  logic [9:0]  regAddr;
  logic [15:0] regWrData;

  int nRun = 0, nFail = 0;
  int evN = 0;
  logic [2:0]  evStb  [64];
  logic [9:0]  evAddr [64];
  logic [15:0] evData [64];

  always #(SER_PERIOD/2)  serClk  = ~serClk;
  always #(CORE_PERIOD/2) coreClk = ~coreClk;

  cmd_frame_rx uut (
    .serClk(serClk), .serRstN(serRstN), .serSync(serSync), .serData(serData),
    .coreClk(coreClk), .coreRstN(coreRstN),
    .regWrStb(regWrStb), .regRdStb(regRdStb), .frameErr(frameErr),
    .regAddr(regAddr), .regWrData(regWrData)
  );

  always @(negedge coreClk) begin
    if (coreRstN && (regWrStb || regRdStb || frameErr)) begin
      if (evN < 64) begin
        evStb[evN]  = {regWrStb, regRdStb, frameErr};
        evAddr[evN] = regAddr;
        evData[evN] = regWrData;
      end
      evN++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic driveFrame(input logic [31:0] w, input int nBits,
                            input bit lead, input bit syncLast);
    if (lead) begin
      @(negedge serClk); serSync = 1; serData = 0;
    end
    for (int i = 0; i < nBits; i++) begin
      @(negedge serClk);
      serData = w[31-i];
      serSync = syncLast && (i == nBits - 1);
    end
  endtask

  task automatic idleWait();
    @(negedge serClk); serSync = 0; serData = 0;
    repeat (WAITC) @(negedge coreClk);
  endtask

  function automatic logic [2:0] stbFor(input logic [1:0] k);
    case (k)
      2'd1:    return 3'b100;
      2'd2:    return 3'b010;
      2'd3:    return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string tagFor(input logic [31:0] w, input logic [1:0] k);
    if (k == 2'd0) return "R2";
    if (k == 2'd1) return "R3";
    if (k == 2'd2) return "R4";
    if (w[29:26] != 4'd0) return "R6";
    return "R5";
  endfunction

  task automatic expectOne(input int idx, input logic [31:0] w, input logic [1:0] k,
                           input string tag);
    check(evStb[idx] == stbFor(k), {tag, " R9 strobe kind"}, 32'(evStb[idx]), 32'(stbFor(k)));
    if (k == 2'd1 || k == 2'd2) begin
      check(evAddr[idx] == w[25:16], {tag, " R1 address"}, 32'(evAddr[idx]), 32'(w[25:16]));
      check(evData[idx] == w[15:0], {tag, " R1 data"}, 32'(evData[idx]), 32'(w[15:0]));
    end
  endtask

  initial begin
    #(CORE_PERIOD * 150000);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge serClk);
    // R10: outputs quiet during reset
    check({regWrStb, regRdStb, frameErr} == 3'b000, "R10 in reset",
          32'({regWrStb, regRdStb, frameErr}), 0);
    @(negedge serClk); serRstN = 1;
    @(negedge coreClk); coreRstN = 1;
    repeat (20) @(negedge coreClk);
    check({regWrStb, regRdStb, frameErr} == 3'b000 && evN == 0, "R10 after reset",
          32'(evN), 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] w;
      logic [1:0]  k;
      string       tag;
      w = VEC[v][33:2];
      k = VEC[v][1:0];
      tag = tagFor(w, k);
      base = evN;
      driveFrame(w, 32, 1'b1, 1'b0);
      idleWait();
      check(evN - base == (k != 2'd0 ? 1 : 0), {tag, " R9 pulse count"},
            32'(evN - base), 32'(k != 2'd0 ? 1 : 0));
      if (k != 2'd0 && evN - base == 1) expectOne(base, w, k, tag);
    end

    // R7: partial word aborted by an early sync
    base = evN;
    driveFrame(32'hC1110123, 20, 1'b1, 1'b0);
    driveFrame(32'hC2AA5555, 32, 1'b1, 1'b0);
    idleWait();
    check(evN - base == 1, "R7 only restarted word delivered", 32'(evN - base), 1);
    if (evN - base == 1) expectOne(base, 32'hC2AA5555, 2'd1, "R7");

    // R8 R11: back-to-back words, sync on bit 0 of the first
    base = evN;
    driveFrame(32'hC0337788, 32, 1'b1, 1'b1);
    driveFrame(32'h80440000, 32, 1'b0, 1'b0);
    idleWait();
    check(evN - base == 2, "R8 both back-to-back words", 32'(evN - base), 2);
    if (evN - base == 2) begin
      expectOne(base,     32'hC0337788, 2'd1, "R11 first");
      expectOne(base + 1, 32'h80440000, 2'd2, "R11 second");
    end

    // R9: quiet afterwards
    repeat (20) @(negedge coreClk);
    check({regWrStb, regRdStb, frameErr} == 3'b000, "R9 idle after traffic",
          32'({regWrStb, regRdStb, frameErr}), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule